// File: doc/BRIEF.md
# SMBus Block Register Slave

This block is a serial-bus slave that gives a host access to a bank of 8-bit configuration registers. The host sees one fixed 7-bit device address (0xD2 as the write address byte, 0xD3 as the read address byte) and moves data in count-prefixed blocks. A write carries a starting register index, a byte count, and then that many data bytes. A read first sets the index with a short write, then issues a repeated start with the read address. The slave answers with a byte count taken from a writable register, then with the register contents.

The bus pins are a serial clock input and an open-drain data line, split into a sampled input and a drive-low enable. Both pins are brought into the system clock domain through synchronizers, so start, stop and clock edges are seen as single-cycle events. The registers are also presented as a flat parallel bus for the rest of the chip. The low five bits of register 5 are read-only status taken from an input port.

Top module: `smbus_cfg_slave`

## Requirements
- R1: The address byte 0xD2 (write) and the address byte 0xD3 (read) are acknowledged by pulling the data line low in the ninth clock. Any other address byte is left unacknowledged, and every byte that follows is ignored until the next start.
- R2: A write of index N, count X and X data bytes stores the data in registers N through N+X-1, in order. The data appears on the parallel register bus, where register i occupies bits [8i+7:8i].
- R3: The slave acknowledges the address, the index, the count and every data byte within the count. It changes its drive only while SCL is low.
- R4: A read (0xD3 after a repeated start) returns the value of the count register first. It then returns registers starting at the current index, in ascending order. The index persists between transactions, so a read with no index phase continues from where the last transfer left off.
- R5: Once it has returned as many data bytes as the count register holds, the slave stops driving. Any further byte the host clocks reads as 0xFF.
- R6: After a host not-acknowledge, the slave releases the data line and waits for a stop or a repeated start. A later transaction then works normally.
- R7: Register 8 resets to 0x0F, can be written, and sets the length of every later read.
- R8: Bits 4:0 of register 5 always show the status input, and writes to those bits are ignored. Bits 7:5 of register 5 are ordinary writable storage.
- R9: A start condition in the middle of a byte abandons the transfer and returns the slave to address matching. The register index keeps its value.
- R10: A stop condition in the middle of a data byte abandons the transfer, and nothing is stored.
- R11: Data bytes beyond the host's count are not acknowledged and not stored.
- R12: After reset, every register reads 0x00 except register 8 (0x0F) and the status bits of register 5, and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Sampled level of the open-drain data line |
| sda_oe_o | output | 1 | When high, the pad pulls the data line low |
| ro_status_i | input | 8 | Status bits; those under the read-only mask appear in register 5 |
| regs_o | output | NUM_REGS*8 | Flat parallel view of all registers |

## Verification
The assertions assume the host changes SDA only while SCL is low, except when it forms a start or a stop. They also assume each SCL high and low phase lasts longer than the synchronizer latency and that the line is a wired-AND of host and slave. Under those conditions a drive change can follow only a detected SCL fall, and a start or stop always finds the line released. The bench resolves the line as the AND of its own drive and the slave's enable. It holds every SCL phase for eight system clocks, changes its data only after its own falling edge, and places aborts and stops only at bit boundaries where SCL is low.

// File: rtl/smbrf_pkg.sv
package smbrf_pkg;

  // Bit-level state of the protocol engine.
  typedef enum logic [2:0] {
    ST_IDLE,   // no transaction in progress
    ST_RX,     // shifting a byte in from the host
    ST_ACK,    // slave holds the line low for the ninth clock
    ST_TX,     // shifting a byte out to the host
    ST_HACK,   // host acknowledge slot after a transmitted byte
    ST_WAIT    // released, waiting for start or stop
  } smb_st_t;

  // Which byte of the transaction is being handled.
  typedef enum logic [2:0] {
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_READ
  } smb_ph_t;

endpackage

// File: rtl/smbrf_line_mon.sv
module smbrf_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic                   scl_d, sda_d;

  // Synchronizer chains; idle bus level is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[SYNC_STAGES-1];
      sda_d    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  =  scl_s & ~scl_d;
  assign scl_fall  = ~scl_s &  scl_d;
  // Data edges while the clock stays high mark bus conditions.
  assign start_det = scl_s & scl_d &  sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d &  sda_s;

endmodule

// File: rtl/smbrf_reg_bank.sv
module smbrf_reg_bank #(
  parameter int          NUM_REGS = 26,
  parameter int          CNT_REG  = 8,
  parameter logic [7:0]  CNT_RST  = 8'h0F,
  parameter int          RO_REG   = 5,
  parameter logic [7:0]  RO_MASK  = 8'h1F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  output logic [7:0]            rd_data,
  output logic [7:0]            cnt_val,
  input  logic [7:0]            ro_status,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  localparam int IW = $clog2(NUM_REGS);

  logic [7:0] vis [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RV = (g == CNT_REG) ? CNT_RST : 8'h00;
    localparam logic [7:0] WM = (g == RO_REG)  ? ~RO_MASK : 8'hFF;

    logic [7:0] q;
    logic       we;

    assign we = wr_en && (wr_idx == 8'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RV & WM;
      else if (we) q <= wr_data & WM;
    end

    if (g == RO_REG) begin : g_ro
      assign vis[g] = (q & ~RO_MASK) | (ro_status & RO_MASK);
    end else begin : g_rw
      assign vis[g] = q;
    end

    assign regs_flat[g*8 +: 8] = vis[g];
  end

  assign rd_data = (rd_idx < 8'(NUM_REGS)) ? vis[rd_idx[IW-1:0]] : 8'h00;
  assign cnt_val = vis[CNT_REG];

endmodule

// File: rtl/smbrf_engine.sv
module smbrf_engine
  import smbrf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] cnt_val,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);

  smb_st_t    st_q, st_n;
  smb_ph_t    ph_q, ph_n;
  logic [3:0] bit_q, bit_n;
  logic [7:0] sh_q, sh_n;     // receive shifter
  logic [7:0] tx_q, tx_n;     // transmit shifter
  logic [7:0] idx_q, idx_n;   // register pointer
  logic [7:0] left_q, left_n; // bytes remaining in the block
  logic       rw_q, rw_n;
  logic       hack_q, hack_n;
  logic       oe_q, oe_n;

  always_comb begin
    st_n    = st_q;
    ph_n    = ph_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    tx_n    = tx_q;
    idx_n   = idx_q;
    left_n  = left_q;
    rw_n    = rw_q;
    hack_n  = hack_q;
    oe_n    = oe_q;
    wr_en   = 1'b0;
    wr_idx  = idx_q;
    wr_data = sh_q;

    if (start_det) begin
      st_n  = ST_RX;
      ph_n  = PH_ADDR;
      bit_n = 4'd0;
      oe_n  = 1'b0;
    end else if (stop_det) begin
      st_n  = ST_IDLE;
      oe_n  = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && bit_q < 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            bit_n = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            st_n = ST_ACK;
            oe_n = 1'b1;
            unique case (ph_q)
              PH_ADDR: begin
                if (sh_q[7:1] == DEV_ADDR) rw_n = sh_q[0];
                else begin
                  st_n = ST_WAIT;
                  oe_n = 1'b0;
                end
              end
              PH_INDEX: idx_n  = sh_q;
              PH_COUNT: left_n = sh_q;
              PH_WDATA: begin
                wr_en  = 1'b1;
                idx_n  = idx_q + 8'd1;
                left_n = left_q - 8'd1;
              end
              default: begin
                st_n = ST_WAIT;
                oe_n = 1'b0;
              end
            endcase
          end
        end

        ST_ACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            bit_n = 4'd0;
            st_n  = ST_RX;
            unique case (ph_q)
              PH_ADDR: begin
                if (rw_q) begin
                  ph_n   = PH_READ;
                  st_n   = ST_TX;
                  left_n = cnt_val;
                  oe_n   = ~cnt_val[7];
                  tx_n   = {cnt_val[6:0], 1'b0};
                  bit_n  = 4'd1;
                end else begin
                  ph_n = PH_INDEX;
                end
              end
              PH_INDEX: ph_n = PH_COUNT;
              PH_COUNT: begin
                if (left_q == 8'd0) st_n = ST_WAIT;
                else                ph_n = PH_WDATA;
              end
              default: begin
                if (left_q == 8'd0) st_n = ST_WAIT;
              end
            endcase
          end
        end

        ST_TX: begin
          if (scl_fall) begin
            if (bit_q < 4'd8) begin
              oe_n  = ~tx_q[7];
              tx_n  = {tx_q[6:0], 1'b0};
              bit_n = bit_q + 4'd1;
            end else begin
              oe_n = 1'b0;
              st_n = ST_HACK;
            end
          end
        end

        ST_HACK: begin
          if (scl_rise) begin
            hack_n = ~sda_s;
          end else if (scl_fall) begin
            if (hack_q && left_q != 8'd0) begin
              st_n   = ST_TX;
              oe_n   = ~rd_data[7];
              tx_n   = {rd_data[6:0], 1'b0};
              bit_n  = 4'd1;
              idx_n  = idx_q + 8'd1;
              left_n = left_q - 8'd1;
            end else begin
              st_n = ST_WAIT;
            end
          end
        end

        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_ADDR;
      bit_q  <= 4'd0;
      sh_q   <= 8'h00;
      tx_q   <= 8'h00;
      idx_q  <= 8'h00;
      left_q <= 8'h00;
      rw_q   <= 1'b0;
      hack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      tx_q   <= tx_n;
      idx_q  <= idx_n;
      left_q <= left_n;
      rw_q   <= rw_n;
      hack_q <= hack_n;
      oe_q   <= oe_n;
    end
  end

  assign rd_idx = idx_q;
  assign sda_oe = oe_q;

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave #(
  parameter int          NUM_REGS    = 26,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int          CNT_REG     = 8,
  parameter logic [7:0]  CNT_RST     = 8'h0F,
  parameter int          RO_REG      = 5,
  parameter logic [7:0]  RO_MASK     = 8'h1F,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [7:0]            ro_status_i,
  output logic [NUM_REGS*8-1:0] regs_o
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  // Assert asynchronously, release on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] cnt_val, rd_data, rd_idx, wr_idx, wr_data;
  logic       wr_en;

  smbrf_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smbrf_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .cnt_val   (cnt_val),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe_o)
  );

  smbrf_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .CNT_REG  (CNT_REG),
    .CNT_RST  (CNT_RST),
    .RO_REG   (RO_REG),
    .RO_MASK  (RO_MASK)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .cnt_val   (cnt_val),
    .ro_status (ro_status_i),
    .regs_flat (regs_o)
  );

endmodule

// File: rtl/smbus_cfg_slave_chk.sv
module smbus_cfg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       start_det,
  input logic       stop_det,
  input logic       wr_en,
  input logic [7:0] cur_idx
);

  // R3: drive changes only follow a low synchronized clock
  assert_drive_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R2: every stored byte is acknowledged on the next cycle
  assert_store_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  // R9: a start leaves the line released
  assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R9: a start never moves the register pointer
  assert_start_keeps_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> $stable(cur_idx));

  // R10: a stop leaves the line released and stores nothing
  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !wr_en));

endmodule

bind smbus_cfg_slave smbus_cfg_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .scl_s     (scl_s),
  .sda_oe    (sda_oe_o),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_en     (wr_en),
  .cur_idx   (rd_idx)
);

// File: tb/smbus_cfg_slave_bench.sv
module smbus_cfg_slave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;     // system clocks per SCL phase
  localparam int NREG       = 26;
  localparam int WD_LIMIT   = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              scl = 1'b1;
  logic              host_sda = 1'b1;
  logic [7:0]        status = 8'h00;
  logic              sda_oe;
  logic [NREG*8-1:0] regs;
  wire               sda_bus = host_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_cfg_slave u_smbus_cfg_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .ro_status_i (status),
    .regs_o      (regs)
  );

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] mdl [NREG];

  // Scoreboard: driver pushes expectations, monitor compares.
  int    exp_v [$];
  string exp_t [$];
  int    obs_val;
  event  obs_ev;

  always @(obs_ev) begin
    n_chk++;
    if (exp_v.size() == 0) begin
      n_fail++;
      $display("FAIL scoreboard: unexpected item actual=%0h expected=none", obs_val);
    end else begin
      automatic int    ev = exp_v.pop_front();
      automatic string tg = exp_t.pop_front();
      if (obs_val != ev) begin
        n_fail++;
        $display("FAIL %s: actual=%0h expected=%0h", tg, obs_val, ev);
      end
    end
  end

  task automatic expect_item(input int v, input string tg);
    exp_v.push_back(v);
    exp_t.push_back(tg);
  endtask

  task automatic observe(input int v);
    obs_val = v;
    -> obs_ev;
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tg, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tg, act, expv);
    end
  endtask

  function automatic logic [7:0] exp_reg(input int i);
    if (i == 5) return (mdl[i] & 8'hE0) | (status & 8'h1F);
    return mdl[i];
  endfunction

  task automatic check_regs(input string tg);
    for (int i = 0; i < NREG; i++)
      chk(regs[i*8 +: 8] == exp_reg(i), tg, regs[i*8 +: 8], exp_reg(i));
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    host_sda = 1'b1; hw(H);
    scl = 1'b1;      hw(H);
    host_sda = 1'b0; hw(H);
    scl = 1'b0;      hw(H);
  endtask

  task automatic bus_stop;
    host_sda = 1'b0; hw(H);
    scl = 1'b1;      hw(H);
    host_sda = 1'b1; hw(H);
  endtask

  task automatic send_bit(input logic b);
    host_sda = b; hw(H);
    scl = 1'b1;   hw(H);
    scl = 1'b0;   hw(H);
  endtask

  task automatic get_bit(output logic b);
    host_sda = 1'b1; hw(H);
    scl = 1'b1;      hw(H/2);
    b = sda_bus;     hw(H/2);
    scl = 1'b0;      hw(H);
  endtask

  // Send a byte and score the acknowledge bit (0 = acked).
  task automatic send_byte(input logic [7:0] v, input int exp_ack, input string tg);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    expect_item(exp_ack, tg);
    get_bit(a);
    observe(int'(a));
  endtask

  task automatic send_partial(input logic [7:0] v, input int nbits);
    for (int i = 0; i < nbits; i++) send_bit(v[7-i]);
  endtask

  // Receive a byte, score it, then acknowledge or not.
  task automatic get_byte(input logic [7:0] expv, input bit ack_it, input string tg);
    logic [7:0] v;
    logic       b;
    expect_item(int'(expv), tg);
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    observe(int'(v));
    send_bit(ack_it ? 1'b0 : 1'b1);
  endtask

  task automatic blk_write(input logic [7:0] idx, input int cnt,
                           input logic [7:0] d [4], input string tg);
    bus_start;
    send_byte(8'hD2, 0, tg);
    send_byte(idx, 0, tg);
    send_byte(8'(cnt), 0, tg);
    for (int i = 0; i < cnt; i++) begin
      send_byte(d[i], 0, tg);
      mdl[int'(idx) + i] = d[i];
    end
    bus_stop;
  endtask

  initial begin : watchdog
    hw(WD_LIMIT);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=<%0d cycles", WD_LIMIT, WD_LIMIT);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] z4 [4];
    z4 = '{8'h00, 8'h00, 8'h00, 8'h00};
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    mdl[8] = 8'h0F;

    hw(5);
    rst_n = 1'b1;
    hw(5);

    // R12 reset image, R7 count default
    check_regs("R12 reset value");
    chk(regs[8*8 +: 8] == 8'h0F, "R7 count reset", regs[8*8 +: 8], 8'h0F);
    chk(sda_oe == 1'b0, "R12 line released", sda_oe, 0);

    // R2 / R3 block write at index 0
    blk_write(8'h00, 4, '{8'hA1, 8'hB2, 8'hC3, 8'hD4}, "R3 write ack");
    check_regs("R2 block write stored");

    // R11 extra byte beyond count
    bus_start;
    send_byte(8'hD2, 0, "R1 write address ack");
    send_byte(8'h0A, 0, "R3 index ack");
    send_byte(8'h01, 0, "R3 count ack");
    send_byte(8'h5A, 0, "R3 data ack");
    send_byte(8'h77, 1, "R11 excess byte not acked");
    bus_stop;
    mdl[10] = 8'h5A;
    check_regs("R11 excess byte not stored");

    // R7 shorten read length to 4
    blk_write(8'h08, 1, '{8'h04, 8'h00, 8'h00, 8'h00}, "R7 count write ack");
    chk(regs[8*8 +: 8] == 8'h04, "R7 count written", regs[8*8 +: 8], 8'h04);

    // R4 / R5 read from index 0
    bus_start;
    send_byte(8'hD2, 0, "R4 set index");
    send_byte(8'h00, 0, "R4 set index");
    bus_start;
    send_byte(8'hD3, 0, "R1 read address ack");
    get_byte(8'h04, 1, "R4 count byte first");
    get_byte(8'hA1, 1, "R4 data reg0");
    get_byte(8'hB2, 1, "R4 data reg1");
    get_byte(8'hC3, 1, "R4 data reg2");
    get_byte(8'hD4, 1, "R4 data reg3");
    get_byte(8'hFF, 0, "R5 released after count");
    bus_stop;

    // R1 foreign address is ignored until the next start
    bus_start;
    send_byte(8'hA0, 1, "R1 foreign address nack");
    send_byte(8'h00, 1, "R1 ignored after mismatch");
    send_byte(8'h01, 1, "R1 ignored after mismatch");
    bus_stop;
    check_regs("R1 no store after mismatch");

    // R8 read-only status bits
    status = 8'h15;
    blk_write(8'h05, 1, '{8'hFF, 8'h00, 8'h00, 8'h00}, "R8 write ack");
    check_regs("R8 status merged");
    chk(regs[5*8 +: 8] == 8'hF5, "R8 reg5 value", regs[5*8 +: 8], 8'hF5);
    status = 8'h0A;
    hw(2);
    chk(regs[5*8 +: 8] == 8'hEA, "R8 status follows input", regs[5*8 +: 8], 8'hEA);

    // R6 host nack right after the count byte
    bus_start;
    send_byte(8'hD2, 0, "R6 set index");
    send_byte(8'h05, 0, "R6 set index");
    bus_start;
    send_byte(8'hD3, 0, "R6 read address");
    get_byte(8'h04, 0, "R6 count then nack");
    chk(sda_oe == 1'b0, "R6 line released after nack", sda_oe, 0);
    bus_stop;
    // R4 read without index phase continues at the pointer
    bus_start;
    send_byte(8'hD3, 0, "R6 next transaction");
    get_byte(8'h04, 1, "R6 count again");
    get_byte(8'hEA, 0, "R4 pointer persists");
    bus_stop;

    // R9 start inside a byte aborts; pointer keeps its value
    blk_write(8'h01, 2, '{8'h11, 8'h22, 8'h00, 8'h00}, "R9 setup write");
    bus_start;
    send_byte(8'hD2, 0, "R9 address");
    send_partial(8'h0C, 4);
    bus_start;
    send_byte(8'hD3, 0, "R9 address after abort");
    get_byte(8'h04, 1, "R9 count");
    get_byte(8'hD4, 0, "R9 index unchanged");
    bus_stop;
    check_regs("R9 no store on abort");

    // R10 stop inside a data byte
    bus_start;
    send_byte(8'hD2, 0, "R10 address");
    send_byte(8'h0C, 0, "R10 index");
    send_byte(8'h01, 0, "R10 count");
    send_partial(8'h99, 4);
    bus_stop;
    hw(H);
    chk(regs[12*8 +: 8] == 8'h00, "R10 nothing stored", regs[12*8 +: 8], 8'h00);
    check_regs("R10 image intact");

    hw(H);
    chk(exp_v.size() == 0, "scoreboard drained", exp_v.size(), 0);
    if (z4[0] != 8'h00) $display("unreachable");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule